// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block resolves one 6-bit operand specifier of a 16-bit instruction into the operand's location. The specifier holds an addressing mode in its upper three bits and a register number in its lower three bits. The block applies all eight modes the same way to every one of the eight general registers, including the stack pointer (register 6) and the program counter (register 7). The operand is either the register itself or a memory address, and the register may be stepped. Some modes use an index word taken from the instruction stream. Deferred modes fetch a pointer from memory before the final address is known.

The surrounding datapath pulses `start` with the specifier, the operation size, the current register-file contents and the index word that follows in the instruction stream. The register file and the index word must stay stable until `done`. For register 7, the supplied value is the address of the next instruction-stream word. Modes 2, 3, 6 and 7 on register 7 therefore give immediate, absolute, relative and relative-deferred addressing.

The result is presented for one cycle with `done`. It carries the effective address or a register-direct flag, a register write-back request, and a flag that marks consumption of an instruction-stream word. Deferred modes first raise a memory read request and wait for its acknowledge.

Top module: `opnd_addr_gen`

## Requirements
- R1: The specifier is split as mode = bits [5:3] and register = bits [2:0]. Mode 0 gives `reg_direct`=1 and `eff_addr`=0, with no write-back and no memory request. `done` is high in the cycle after `start`.
- R2: Mode 1 gives `eff_addr` equal to the register value, with no write-back.
- R3: Mode 2 gives `eff_addr` equal to the register value and writes back the register plus a step. The step is 1 when `byte_op`=1 and the register is 0 to 5, and 2 otherwise.
- R4: Mode 4 gives both `eff_addr` and the written-back value equal to the register minus the same step as R3, with 16-bit wraparound.
- R5: Mode 3 reads memory at the register value, gives `eff_addr` equal to the word read, and writes back the register plus 2.
- R6: Mode 5 writes back the register minus 2, reads memory at that decremented value, and gives `eff_addr` equal to the word read.
- R7: Mode 6 gives `eff_addr` = register + index word, or register + 2 + index word for register 7, with no write-back. Mode 7 reads memory at that sum and gives `eff_addr` equal to the word read.
- R8: `extra_word` is 1 for modes 6 and 7 on any register, and for modes 2 and 3 on register 7; it is 0 otherwise.
- R9: In deferred modes (3, 5, 7), `mem_req` rises in the cycle after `start` and holds a stable `mem_addr` until an acknowledge is sampled. `done` follows in the next cycle. A non-deferred mode never raises `mem_req`.
- R10: A `start` pulse while `busy`=1 is ignored, and the pending operation completes with its original results.
- R11: After reset, `done`, `mem_req`, `wb_en` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving `spec` |
| spec | input | 6 | Operand specifier: mode [5:3], register [2:0] |
| byte_op | input | 1 | Operation is byte sized |
| regs_flat | input | 128 | Register file, register n at bits [16n+15:16n] |
| index_word | input | 16 | Next instruction-stream word |
| busy | output | 1 | Waiting for a deferred read |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | Result valid, one cycle |
| reg_direct | output | 1 | Operand is the register itself |
| eff_addr | output | 16 | Effective address |
| wb_en | output | 1 | Register write-back request, valid with `done` |
| wb_idx | output | 3 | Register to write back |
| wb_val | output | 16 | Write-back value |
| extra_word | output | 1 | An instruction-stream word was consumed |

## Verification
The bench builds the block with its default parameters: 16-bit data and eight registers, so the stack pointer and program counter sit at indices 6 and 7. This puts every mode-and-register pair within reach, along with both the byte step on registers 0 to 5 and the forced word step on 6 and 7. A 16-bit width lets decrement wrap below zero and lets index sums overflow, and directed cases aim at both. Acknowledge delays of zero to three cycles cover an immediate answer and a held request.

// File: rtl/oag_pkg.sv
package oag_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_REG    = 3'd0,
    AM_DEF    = 3'd1,
    AM_INC    = 3'd2,
    AM_INC_D  = 3'd3,
    AM_DEC    = 3'd4,
    AM_DEC_D  = 3'd5,
    AM_IDX    = 3'd6,
    AM_IDX_D  = 3'd7
  } amode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/oag_decode.sv
module oag_decode
  import oag_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7,
  localparam int RIDX_W = $clog2(NREGS),
  localparam int SPEC_W = MODE_W + RIDX_W
) (
  input  logic [SPEC_W-1:0] spec,
  input  logic              byte_op,
  output amode_e            mode,
  output logic [RIDX_W-1:0] rsel,
  output logic              is_pc,
  output logic              deferred,
  output logic              is_direct,
  output logic              wide_step,
  output logic              extra
);
  always_comb begin
    mode      = amode_e'(spec[SPEC_W-1 -: MODE_W]);
    rsel      = spec[RIDX_W-1:0];
    is_pc     = (rsel == RIDX_W'(PC_IDX));
    deferred  = (mode == AM_INC_D) || (mode == AM_DEC_D) || (mode == AM_IDX_D);
    is_direct = (mode == AM_REG);
    // byte stepping only applies to ordinary registers
    wide_step = !byte_op || (rsel == RIDX_W'(SP_IDX)) || is_pc;
    extra     = (mode == AM_IDX) || (mode == AM_IDX_D) ||
                (is_pc && ((mode == AM_INC) || (mode == AM_INC_D)));
  end
endmodule

// File: rtl/oag_calc.sv
module oag_calc
  import oag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREGS  = 8,
  localparam int RIDX_W = $clog2(NREGS)
) (
  input  logic [NREGS*DATA_W-1:0] regs_flat,
  input  logic [RIDX_W-1:0]       rsel,
  input  amode_e                  mode,
  input  logic                    is_pc,
  input  logic                    wide_step,
  input  logic [DATA_W-1:0]       index_word,
  output logic [DATA_W-1:0]       ptr,
  output logic                    wb_need,
  output logic [DATA_W-1:0]       wb_calc
);
  localparam logic [DATA_W-1:0] TWO = DATA_W'(2);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] reg_arr [NREGS];
  logic [DATA_W-1:0] rval, step, base_idx;

  for (genvar g = 0; g < NREGS; g++) begin : g_unpack
    assign reg_arr[g] = regs_flat[g*DATA_W +: DATA_W];
  end

  assign rval     = reg_arr[rsel];
  assign step     = wide_step ? TWO : ONE;
  // the index is added to the program counter after it has passed the index word
  assign base_idx = is_pc ? rval + TWO : rval;

  always_comb begin
    ptr     = rval;
    wb_need = 1'b0;
    wb_calc = rval;
    unique case (mode)
      AM_REG, AM_DEF: begin
        ptr = rval;
      end
      AM_INC: begin
        ptr     = rval;
        wb_need = 1'b1;
        wb_calc = rval + step;
      end
      AM_INC_D: begin
        ptr     = rval;
        wb_need = 1'b1;
        wb_calc = rval + TWO;
      end
      AM_DEC: begin
        ptr     = rval - step;
        wb_need = 1'b1;
        wb_calc = rval - step;
      end
      AM_DEC_D: begin
        ptr     = rval - TWO;
        wb_need = 1'b1;
        wb_calc = rval - TWO;
      end
      AM_IDX, AM_IDX_D: begin
        ptr = base_idx + index_word;
      end
      default: ptr = rval;
    endcase
  end
endmodule

// File: rtl/oag_ctrl.sv
module oag_ctrl
  import oag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREGS  = 8,
  localparam int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              deferred,
  input  logic              is_direct,
  input  logic              extra,
  input  logic [DATA_W-1:0] ptr,
  input  logic              wb_need,
  input  logic [DATA_W-1:0] wb_calc,
  input  logic [RIDX_W-1:0] rsel,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  output logic              done,
  output logic              reg_direct,
  output logic [DATA_W-1:0] eff_addr,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [DATA_W-1:0] wb_val,
  output logic              extra_word
);
  ctl_state_e state;
  logic       wbe_q;
  logic       accept;

  assign accept = start && (state == ST_IDLE);
  assign busy   = (state == ST_WAIT);
  assign wb_en  = done && wbe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      eff_addr   <= '0;
      reg_direct <= 1'b0;
      wbe_q      <= 1'b0;
      wb_idx     <= '0;
      wb_val     <= '0;
      extra_word <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            reg_direct <= is_direct;
            wbe_q      <= wb_need;
            wb_idx     <= rsel;
            wb_val     <= wb_calc;
            extra_word <= extra;
            if (deferred) begin
              mem_req  <= 1'b1;
              mem_addr <= ptr;
              state    <= ST_WAIT;
            end else begin
              done     <= 1'b1;
              eff_addr <= is_direct ? '0 : ptr;
            end
          end
        end
        ST_WAIT: begin
          if (mem_ack) begin
            mem_req  <= 1'b0;
            eff_addr <= mem_rdata;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R9
  ack_done_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> done && !mem_req);
  // R9
  direct_done_chk: assert property (@(posedge clk) disable iff (rst)
    start && !busy && !deferred |=> done && !mem_req);
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    busy && start && !mem_ack |=> busy && $stable(mem_addr) && $stable(wb_val));
  // R1
  direct_nowb_chk: assert property (@(posedge clk) disable iff (rst)
    done && reg_direct |-> !wb_en && eff_addr == '0);
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import oag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREGS  = 8,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7,
  localparam int RIDX_W = $clog2(NREGS),
  localparam int SPEC_W = MODE_W + RIDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [SPEC_W-1:0]       spec,
  input  logic                    byte_op,
  input  logic [NREGS*DATA_W-1:0] regs_flat,
  input  logic [DATA_W-1:0]       index_word,
  output logic                    busy,
  output logic                    mem_req,
  output logic [DATA_W-1:0]       mem_addr,
  input  logic                    mem_ack,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    done,
  output logic                    reg_direct,
  output logic [DATA_W-1:0]       eff_addr,
  output logic                    wb_en,
  output logic [RIDX_W-1:0]       wb_idx,
  output logic [DATA_W-1:0]       wb_val,
  output logic                    extra_word
);
  amode_e            mode;
  logic [RIDX_W-1:0] rsel;
  logic              is_pc, deferred, is_direct, wide_step, extra;
  logic [DATA_W-1:0] ptr, wb_calc;
  logic              wb_need;

  oag_decode #(.NREGS(NREGS), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_dec (
    .spec(spec), .byte_op(byte_op), .mode(mode), .rsel(rsel), .is_pc(is_pc),
    .deferred(deferred), .is_direct(is_direct), .wide_step(wide_step),
    .extra(extra)
  );

  oag_calc #(.DATA_W(DATA_W), .NREGS(NREGS)) u_calc (
    .regs_flat(regs_flat), .rsel(rsel), .mode(mode), .is_pc(is_pc),
    .wide_step(wide_step), .index_word(index_word), .ptr(ptr),
    .wb_need(wb_need), .wb_calc(wb_calc)
  );

  oag_ctrl #(.DATA_W(DATA_W), .NREGS(NREGS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .deferred(deferred),
    .is_direct(is_direct), .extra(extra), .ptr(ptr), .wb_need(wb_need),
    .wb_calc(wb_calc), .rsel(rsel), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .done(done),
    .reg_direct(reg_direct), .eff_addr(eff_addr), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_val(wb_val), .extra_word(extra_word)
  );

  // R8
  extra_mode_chk: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (mode == AM_REG || mode == AM_DEF || mode == AM_DEC ||
                       mode == AM_DEC_D) |=> !extra_word);
endmodule

// File: tb/tb_opnd_addr_gen.sv
module tb_opnd_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NR = 8;

  logic          clk = 0;
  logic          rst = 1;
  logic          start = 0;
  logic [5:0]    spec = '0;
  logic          byte_op = 0;
  logic [NR*DW-1:0] regs_flat = '0;
  logic [DW-1:0] index_word = '0;
  logic          busy, mem_req, mem_ack = 0;
  logic [DW-1:0] mem_addr, mem_rdata = '0;
  logic          done, reg_direct, wb_en, extra_word;
  logic [DW-1:0] eff_addr, wb_val;
  logic [2:0]    wb_idx;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] rf [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_addr_gen dut (
    .clk(clk), .rst(rst), .start(start), .spec(spec), .byte_op(byte_op),
    .regs_flat(regs_flat), .index_word(index_word), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .reg_direct(reg_direct),
    .eff_addr(eff_addr), .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val),
    .extra_word(extra_word)
  );

  function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (spec %o byte %0d)", req, act, exp, spec, byte_op);
    end
  endtask

  task automatic pack_regs();
    for (int i = 0; i < NR; i++) regs_flat[i*DW +: DW] = rf[i];
  endtask

  // expected results from the requirements
  task automatic run_op(input logic [5:0] sp, input logic bop, input logic [DW-1:0] x,
                        input int delay, input bit poke_busy);
    logic [2:0] m, r;
    logic [DW-1:0] rv, stp, ptr, wbv, ea;
    logic def, wbe, ext, dir;
    m = sp[5:3]; r = sp[2:0]; rv = rf[r];
    stp = (bop && r < 6) ? 16'd1 : 16'd2;
    def = (m == 3 || m == 5 || m == 7);
    dir = (m == 0);
    ext = (m == 6 || m == 7 || (r == 7 && (m == 2 || m == 3)));
    wbe = (m >= 2 && m <= 5);
    ptr = rv; wbv = rv;
    case (m)
      3'd2: wbv = rv + stp;                         // R3
      3'd3: wbv = rv + 16'd2;                       // R5
      3'd4: begin ptr = rv - stp; wbv = ptr; end    // R4
      3'd5: begin ptr = rv - 16'd2; wbv = ptr; end  // R6
      3'd6, 3'd7: ptr = rv + ((r == 7) ? 16'd2 : 16'd0) + x; // R7
      default: ;
    endcase
    ea = dir ? 16'd0 : (def ? memf(ptr) : ptr);

    @(negedge clk);
    spec = sp; byte_op = bop; index_word = x; start = 1;
    @(negedge clk);
    start = 0;
    if (def) begin
      chk("R9 req", {15'd0, mem_req}, 16'd1);
      chk("R9 addr", mem_addr, ptr);
      chk("R9 no early done", {15'd0, done}, 16'd0);
      for (int d = 0; d < delay; d++) begin
        if (poke_busy && d == 0) begin spec = 6'o00; start = 1; end
        @(negedge clk);
        start = 0;
        chk("R9 hold req", {15'd0, mem_req}, 16'd1);
        chk("R9 stable addr", mem_addr, ptr);
        chk("R10 still busy", {15'd0, busy}, 16'd1);
      end
      mem_ack = 1; mem_rdata = memf(mem_addr);
      @(negedge clk);
      mem_ack = 0; mem_rdata = '0;
    end else begin
      chk("R9 no req", {15'd0, mem_req}, 16'd0);
    end
    chk("R9 done", {15'd0, done}, 16'd1);
    chk("R1 direct", {15'd0, reg_direct}, {15'd0, dir});
    chk(m == 1 ? "R2 addr" : m == 5 ? "R6 addr" : m == 3 ? "R5 addr" :
        m >= 6 ? "R7 addr" : "R3/R4 addr", eff_addr, ea);
    chk("R8 extra", {15'd0, extra_word}, {15'd0, ext});
    chk("R3 wb_en", {15'd0, wb_en}, {15'd0, wbe});
    if (wbe) begin
      chk("R4 wb_val", wb_val, wbv);
      chk("R6 wb_idx", {13'd0, wb_idx}, {13'd0, r});
    end
    if (poke_busy) chk("R10 poke ignored", eff_addr, ea);
    @(negedge clk);
    chk("R9 done pulse", {15'd0, done}, 16'd0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) rf[i] = 16'h1000 * i[15:0] + 16'h0100;
    pack_regs();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done", {15'd0, done}, 16'd0);
    chk("R11 mem_req", {15'd0, mem_req}, 16'd0);
    chk("R11 wb_en", {15'd0, wb_en}, 16'd0);
    chk("R11 busy", {15'd0, busy}, 16'd0);
    rst = 0;

    // directed corners
    run_op(6'o03, 0, 16'h0, 0, 0);           // R1 register mode
    run_op(6'o12, 0, 16'h0, 0, 0);           // R2
    run_op(6'o20, 1, 16'h0, 0, 0);           // R3 byte step 1
    run_op(6'o26, 1, 16'h0, 0, 0);           // R3 SP forced 2
    run_op(6'o27, 1, 16'h0, 0, 0);           // R3/R8 immediate on PC
    run_op(6'o45, 1, 16'h0, 0, 0);           // R4 byte step 1
    rf[0] = 16'h0000; pack_regs();
    run_op(6'o40, 0, 16'h0, 0, 0);           // R4 wrap to FFFE
    run_op(6'o37, 0, 16'h0, 2, 0);           // R5/R8 absolute
    run_op(6'o51, 0, 16'h0, 1, 0);           // R6
    run_op(6'o67, 0, 16'hFFF0, 0, 0);        // R7 relative
    run_op(6'o64, 0, 16'hF000, 0, 0);        // R7 overflow sum
    run_op(6'o77, 0, 16'h0020, 3, 1);        // R7 deferred, R10 poke
    run_op(6'o31, 1, 16'h0, 2, 1);           // R10 poke, R5 byte ignored

    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < NR; i++) rf[i] = 16'($urandom);
      pack_regs();
      run_op(6'($urandom), 1'($urandom), 16'($urandom), int'($urandom % 4),
             ($urandom % 8) == 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule